// File: doc/BRIEF.md
# Performance Event Counter Bank

This block holds a small bank of programmable 32-bit event counters next to one free-running cycle counter. Each event counter owns a type register whose event-number field picks one of the `NUM_EVT` single-cycle event inputs. A counter advances by one on every clock where the global enable is on, its own enable bit is on, and its chosen event input is high. The cycle counter advances on every clock where the global enable and its own enable bit (bit 31) are both on.

Software reaches the bank through a plain register port. The port is made of a 5-bit word address, write data, a write strobe, and read data that follows the address combinationally. Writes take effect at the clock edge where `reg_we` is high. There is no back-pressure: every write is accepted in its cycle, and read data is valid in the cycle its address is driven.

The enable, interrupt-enable and overflow registers hold one bit per implemented counter, with bit 31 for the cycle counter. They are changed by writing ones to set or clear them. A counter can be reached directly at its own address, or indirectly through a select register. An interrupt line reports any overflow whose interrupt is enabled.

Top module: `pec_bank`

## Requirements
- R1: After reset every counter, type, enable, interrupt-enable, overflow and select register reads 0. The control register (address 0x00) reads `NUM_CNT` in bits 15:11, which is 0x2000 for the default of 4 counters, and `irq` is 0.
- R2: No counter changes while control bit 0 (global enable) is 0, even when its enable bit is set and its event input is high.
- R3: Writing ones to the enable-set register (0x01) enables those counters. Writing ones to the enable-clear register (0x02) disables them. Both addresses read the same current enable mask.
- R4: Writes to the enable, interrupt-enable and overflow registers touch only implemented bits: bits 0 to `NUM_CNT`-1 and bit 31. Every other bit reads 0, so writing all ones to 0x01 reads back 0x8000000F by default.
- R5: The interrupt-enable set register (0x03) and clear register (0x04) follow the same paired write-one rules as R3, masked as in R4.
- R6: Writing control bit 1 zeroes all event counters, and writing control bit 2 zeroes the cycle counter. Both bits read back as 0. Control bits 0, 3, 4, 5 and 6 are stored and read back as written.
- R7: An event counter that steps past 0xFFFFFFFF wraps to 0 and sets its own bit in the overflow register (0x05). Writing ones to 0x05 clears those bits.
- R8: The select register (0x06, bits 4:0) names a counter index. Address 0x07 then reads and writes that counter's type register, and address 0x08 its count. Out-of-range indices read 0 and ignore writes.
- R9: A type register (direct address 0x18+i) keeps bits 11:0 (event number) and bits 31:30 (flags); all other bits read 0. A counter counts only the input whose index equals its event number, and never counts when the number is `NUM_EVT` or above.
- R10: An event counter (direct address 0x10+i) rises by exactly one per qualifying clock. A write to a counter in the same cycle as an event loads the written value and drops that event.
- R11: `irq` is high whenever some overflow bit and the matching interrupt-enable bit are both set. It stays high until software clears the overflow bit or the interrupt enable.
- R12: When a counter wraps in the same cycle as a write-one-to-clear of its overflow bit, the bit ends up set.
- R13: The cycle counter (address 0x09) rises by one each clock while control bit 0 and enable bit 31 are both set. When it wraps, it sets overflow bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per high cycle |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_in | input | NUM_EVT | Event pulses, one bit per event number |
| irq | output | 1 | Overflow interrupt request |

## Verification
Two functions can land on the same edge: a counter wrapping, and a software write-one-to-clear of that counter's overflow bit. The bench provokes this by presetting a counter to 0xFFFFFFFF, then raising its event input in exactly the cycle it writes 1 to the overflow register. It expects the bit to stay set and `irq` to stay high. A contrasting clear with no wrap must drop the bit. A second collision is also exercised: a direct count write and a qualifying event in one cycle, where the written value must be the one that stays.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int DW = 32;
  localparam int AW = 5;

  localparam logic [AW-1:0] A_CTRL    = 5'h00;
  localparam logic [AW-1:0] A_ENSET   = 5'h01;
  localparam logic [AW-1:0] A_ENCLR   = 5'h02;
  localparam logic [AW-1:0] A_IESET   = 5'h03;
  localparam logic [AW-1:0] A_IECLR   = 5'h04;
  localparam logic [AW-1:0] A_OVF     = 5'h05;
  localparam logic [AW-1:0] A_SEL     = 5'h06;
  localparam logic [AW-1:0] A_SELTYPE = 5'h07;
  localparam logic [AW-1:0] A_SELCNT  = 5'h08;
  localparam logic [AW-1:0] A_CYC     = 5'h09;

  // direct windows: addr[4]=1, addr[3] picks type (1) or count (0), addr[2:0] index
  localparam logic [DW-1:0] TYPE_KEEP = 32'hC000_0FFF;
  localparam logic [DW-1:0] CTRL_KEEP = 32'h0000_0079;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_EVRS = 1;
  localparam int CTRL_CYRS = 2;
  localparam int NUM_SHIFT = 11;
endpackage

// File: rtl/pec_counter.sv
module pec_counter
  import pec_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          inc,
  output logic [DW-1:0] count,
  output logic          wrap
);
  // priority: clear, then software load, then increment
  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (load)  count <= load_val;
    else if (inc)   count <= count + 1'b1;
  end

  assign wrap = inc && !clear && !load && (&count);

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> count == '0); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !load && !inc) |=> $stable(count)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !load && inc) |=> count == $past(count) + 32'd1); // R10
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && load) |=> count == $past(load_val)); // R10
endmodule

// File: rtl/pec_maskreg.sv
module pec_maskreg
  import pec_pkg::*;
#(
  parameter logic [DW-1:0] MASK = 32'h8000_000F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] hw_set,
  output logic [DW-1:0] q
);
  logic [DW-1:0] set_bits, clr_bits, nxt;

  always_comb begin
    set_bits = set_we ? wdata : '0;
    clr_bits = clr_we ? wdata : '0;
    // hardware set beats a software clear in the same cycle
    nxt = (((q | set_bits) & ~clr_bits) | hw_set) & MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> (q & $past(wdata) & MASK) == ($past(wdata) & MASK)); // R3
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> (q & ~MASK) == '0); // R4
  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> (q & $past(hw_set & MASK)) == $past(hw_set & MASK)); // R12
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we && hw_set == '0) |=> $stable(q)); // R5
endmodule

// File: rtl/pec_bank.sv
module pec_bank
  import pec_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  input  logic               reg_we,
  output logic [DW-1:0]      reg_rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic               irq
);
  localparam int EVW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam logic [DW-1:0] IMPL =
    {1'b1, {(DW-1-NUM_CNT){1'b0}}, {NUM_CNT{1'b1}}};

  logic [DW-1:0] ctrl_q, en_q, ie_q, ovf_q, cyc_cnt, ovf_hw;
  logic [AW-1:0] sel_q;
  logic [DW-1:0] type_q [NUM_CNT];
  logic [DW-1:0] cnt_q  [NUM_CNT];
  logic [NUM_CNT-1:0] wrap, hit;
  logic cyc_wrap, run, ev_rst, cy_rst;

  wire wr_ctrl = reg_we && reg_addr == A_CTRL;
  assign run    = ctrl_q[CTRL_RUN];
  assign ev_rst = wr_ctrl && reg_wdata[CTRL_EVRS];
  assign cy_rst = wr_ctrl && reg_wdata[CTRL_CYRS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sel_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_KEEP;
      if (reg_we && reg_addr == A_SEL) sel_q <= reg_wdata[AW-1:0];
    end
  end

  pec_maskreg #(.MASK(IMPL)) u_en (
    .clk, .rst_n,
    .set_we(reg_we && reg_addr == A_ENSET),
    .clr_we(reg_we && reg_addr == A_ENCLR),
    .wdata(reg_wdata), .hw_set('0), .q(en_q));

  pec_maskreg #(.MASK(IMPL)) u_ie (
    .clk, .rst_n,
    .set_we(reg_we && reg_addr == A_IESET),
    .clr_we(reg_we && reg_addr == A_IECLR),
    .wdata(reg_wdata), .hw_set('0), .q(ie_q));

  always_comb begin
    ovf_hw = '0;
    ovf_hw[NUM_CNT-1:0] = wrap;
    ovf_hw[DW-1] = cyc_wrap;
  end

  pec_maskreg #(.MASK(IMPL)) u_ovf (
    .clk, .rst_n,
    .set_we(1'b0),
    .clr_we(reg_we && reg_addr == A_OVF),
    .wdata(reg_wdata), .hw_set(ovf_hw), .q(ovf_q));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    wire dir_cnt  = reg_addr == (5'h10 + AW'(i));
    wire dir_type = reg_addr == (5'h18 + AW'(i));
    wire picked   = sel_q == AW'(i);
    wire ld_cnt   = reg_we && (dir_cnt  || (reg_addr == A_SELCNT  && picked));
    wire ld_type  = reg_we && (dir_type || (reg_addr == A_SELTYPE && picked));

    always_ff @(posedge clk) begin
      if (!rst_n)       type_q[i] <= '0;
      else if (ld_type) type_q[i] <= reg_wdata & TYPE_KEEP;
    end

    assign hit[i] = (type_q[i][11:0] < 12'(NUM_EVT)) && evt_in[type_q[i][EVW-1:0]];

    pec_counter u_ctr (
      .clk, .rst_n, .clear(ev_rst), .load(ld_cnt), .load_val(reg_wdata),
      .inc(run && en_q[i] && hit[i]), .count(cnt_q[i]), .wrap(wrap[i]));
  end

  pec_counter u_cyc (
    .clk, .rst_n, .clear(cy_rst), .load(reg_we && reg_addr == A_CYC),
    .load_val(reg_wdata), .inc(run && en_q[DW-1]), .count(cyc_cnt),
    .wrap(cyc_wrap));

  assign irq = |(ovf_q & ie_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:           reg_rdata = ctrl_q | (DW'(NUM_CNT) << NUM_SHIFT);
      A_ENSET, A_ENCLR: reg_rdata = en_q;
      A_IESET, A_IECLR: reg_rdata = ie_q;
      A_OVF:            reg_rdata = ovf_q;
      A_SEL:            reg_rdata = DW'(sel_q);
      A_CYC:            reg_rdata = cyc_cnt;
      default: begin
        for (int i = 0; i < NUM_CNT; i++) begin
          if (reg_addr == A_SELTYPE && sel_q == AW'(i))   reg_rdata = type_q[i];
          if (reg_addr == A_SELCNT  && sel_q == AW'(i))   reg_rdata = cnt_q[i];
          if (reg_addr == (5'h10 + AW'(i)))               reg_rdata = cnt_q[i];
          if (reg_addr == (5'h18 + AW'(i)))               reg_rdata = type_q[i];
        end
      end
    endcase
  end

  AST_PULSE_BITS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTRL) |-> reg_rdata[2:1] == 2'b00); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_we && (reg_addr == A_OVF || reg_addr == A_IECLR))) |=> irq); // R11
  AST_OVF_NEEDS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hw == '0 && !(reg_we && reg_addr == A_OVF)) |=> $stable(ovf_q)); // R7
  AST_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reg_we) |=> $stable(cyc_cnt)); // R2
endmodule

// File: tb/pec_bank_test.sv
module pec_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic [7:0]  evt_in = '0;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pec_bank #(.NUM_CNT(4), .NUM_EVT(8)) uut (
    .clk, .rst_n, .reg_addr, .reg_wdata, .reg_we, .reg_rdata, .evt_in, .irq);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive just after a rising edge; the write lands on the next one
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(input int bitn, input int cycles);
    evt_in[bitn] = 1'b1;
    repeat (cycles) @(posedge clk);
    #1 evt_in[bitn] = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(5'h00, v); chk("R1 ctrl", v, 32'h0000_2000);
    rd(5'h01, v); chk("R1 enable", v, 0);
    rd(5'h05, v); chk("R1 overflow", v, 0);
    rd(5'h10, v); chk("R1 count0", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_enables;
    logic [31:0] v;
    wr(5'h01, 32'hFFFF_FFFF);
    rd(5'h01, v); chk("R4 set masked", v, 32'h8000_000F);
    rd(5'h02, v); chk("R3 clr reads mask", v, 32'h8000_000F);
    wr(5'h02, ~32'h3);
    rd(5'h01, v); chk("R3 clear keeps 0,1", v, 32'h0000_0003);
    wr(5'h03, 32'hFFFF_FFFF);
    rd(5'h04, v); chk("R5 ie set masked", v, 32'h8000_000F);
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h03, v); chk("R5 ie cleared", v, 0);
  endtask

  task automatic t_indirect;
    logic [31:0] v;
    wr(5'h06, 32'd1);
    wr(5'h07, 32'hC000_00EA);
    wr(5'h08, 32'hDEAD_BEEF);
    rd(5'h19, v); chk("R8 type via select", v, 32'hC000_00EA);
    rd(5'h11, v); chk("R8 count via select", v, 32'hDEAD_BEEF);
    wr(5'h19, 32'hFFFF_FFFF);
    rd(5'h07, v); chk("R9 type keep bits", v, 32'hC000_0FFF);
    wr(5'h06, 32'd9);
    wr(5'h08, 32'h1234_5678);
    rd(5'h08, v); chk("R8 out of range", v, 0);
    rd(5'h11, v); chk("R8 oor no write", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(5'h00, 32'h0000_0042);
    rd(5'h11, v); chk("R6 event reset", v, 0);
    rd(5'h00, v); chk("R6 ctrl readback", v, 32'h0000_2040);
    wr(5'h00, 32'h0000_0038);
    rd(5'h00, v); chk("R6 bits 3-5", v, 32'h0000_2038);
    wr(5'h00, 32'h0);
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr(5'h18, 32'd2);          // counter0 counts input 2
    wr(5'h19, 32'd5);          // counter1 counts input 5
    wr(5'h1A, 32'd8);          // counter2: out-of-range event
    wr(5'h01, 32'h7);
    pulse(2, 5);
    rd(5'h10, v); chk("R2 halted", v, 0);
    wr(5'h00, 32'h1);
    pulse(2, 5);
    rd(5'h10, v); chk("R10 counted 5", v, 5);
    rd(5'h11, v); chk("R9 other event idle", v, 0);
    evt_in = 8'hFF;
    @(posedge clk); #1 evt_in = '0;
    rd(5'h12, v); chk("R9 event >= NUM_EVT", v, 0);
    rd(5'h11, v); chk("R9 input 5 counted", v, 1);
    evt_in[2] = 1'b1;
    wr(5'h10, 32'd100);
    evt_in[2] = 1'b0;
    rd(5'h10, v); chk("R10 write wins", v, 100);
  endtask

  task automatic t_cycle;
    logic [31:0] v;
    wr(5'h01, 32'h8000_0000);
    wr(5'h09, 32'd100);
    rd(5'h09, v); chk("R13 preset", v, 100);
    repeat (3) @(posedge clk); #1;
    rd(5'h09, v); chk("R13 three clocks", v, 103);
    wr(5'h09, 32'hFFFF_FFFE);
    repeat (2) @(posedge clk); #1;
    rd(5'h09, v); chk("R13 wrap", v, 0);
    rd(5'h05, v); chk("R13 overflow bit31", v, 32'h8000_0000);
    wr(5'h02, 32'h8000_0000);
    wr(5'h00, 32'h5);
    rd(5'h09, v); chk("R6 cycle reset", v, 0);
    wr(5'h05, 32'hFFFF_FFFF);
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    wr(5'h03, 32'h1);
    wr(5'h10, 32'hFFFF_FFF0);
    chk("R11 irq low", {31'b0, irq}, 0);
    pulse(2, 17);
    rd(5'h10, v); chk("R7 wrapped", v, 1);
    rd(5'h05, v); chk("R7 overflow bit0", v, 1);
    chk("R11 irq high", {31'b0, irq}, 1);
    wr(5'h10, 32'hFFFF_FFFF);
    evt_in[2] = 1'b1;
    wr(5'h05, 32'h1);
    evt_in[2] = 1'b0;
    rd(5'h05, v); chk("R12 set beats clear", v, 1);
    chk("R12 irq stays", {31'b0, irq}, 1);
    wr(5'h05, 32'h1);
    rd(5'h05, v); chk("R7 w1c", v, 0);
    chk("R11 irq dropped", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_enables;
    t_indirect;
    t_ctrl;
    t_count;
    t_cycle;
    t_overflow;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule